// File: doc/BRIEF.md
# Dual Programmable PWM Clock Generator

This block derives two independent clock-enable strobes, A and B, from the master clock for a bank of pulse-width channels. Each strobe is the product of a shared power-of-two prescaler and a private 8-bit linear divider. Both are configured by one 32-bit mode word, written and read through a plain register port. Channels that select A or B advance their counters only in cycles where that strobe is high.

The prescaler is one free-running counter. Its carry taps give enables every 2^0 to 2^10 master cycles. Each divider is a two-state machine, IDLE (clock off) and RUN (counting prescaler enables). Its transitions are: IDLE to RUN, when a write brings in a usable setting that differs from the old one; RUN to RUN with the count cleared, when a write changes the setting to another usable one; RUN to IDLE, when a write changes the setting to an unusable one; and the self-loop in either state when no relevant write occurs. A setting is unusable when its divisor is zero or its exponent is above 10. The strobe is high in RUN during a cycle where the selected prescaler enable is high and the count has reached the divisor minus one.

Top module: `pwmclk_dual_gen`

## Requirements
- R1: After reset the mode word reads zero and neither strobe pulses.
- R2: Clock A is set by mode bits [15:0] and clock B by bits [31:16]. In each half, bits [7:0] are the divisor D and bits [11:8] are the exponent E. A read returns the last word written.
- R3: A running clock pulses once every 2^E × D master cycles. Each pulse is one master cycle wide. With E=0 and D=1 the strobe is high in every cycle.
- R4: A half with D=0, or with E in 11 to 15, produces no pulses.
- R5: A write that changes a half's bits [11:0] restarts that divider from zero. With E=0, the first pulse falls in the D-th cycle after the write edge, counting the cycle right after the edge as the first. This holds even when the write lands in a cycle where the old setting pulses; that pulse still appears.
- R6: Without a write, the mode word read back does not change.
- R7: A write that leaves a half's bits [11:0] unchanged does not disturb that clock's pulse spacing.
- R8: Bits [15:12] of each half are stored and read back, but have no effect on the strobes and cause no restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cfg_we | input | 1 | write strobe for the mode word |
| cfg_wdata | input | 32 | mode word to write |
| cfg_rdata | output | 32 | current mode word |
| tick_a | output | 1 | clock A enable strobe |
| tick_b | output | 1 | clock B enable strobe |

## Verification
Two things can happen in the same cycle: a configuration write, and a terminal count that produces a pulse. The bench locks onto a pulse and issues the write in exactly that cycle, once on the clock being changed and once on a half that the write leaves untouched. It also issues writes part-way through a period. Each result is judged by comparing the positions of the following pulses, counted in cycles from the sync pulse, with positions worked out from the restart and period rules: the restarted clock must realign, and the untouched clock must keep its spacing.

// File: rtl/pwmclk_pkg.sv
package pwmclk_pkg;
    typedef enum logic [0:0] {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/pwmclk_prescaler.sv
module pwmclk_prescaler #(
    parameter int PRE_MAX = 10,
    parameter int EXP_W   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    output logic [(1<<EXP_W)-1:0]   stride_en
);
    localparam int TAP_N = 1 << EXP_W;

    logic [PRE_MAX-1:0] ripple_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ripple_q <= '0;
        else        ripple_q <= ripple_q + 1'b1;
    end

    // tap k is high once every 2^k cycles: when the low k bits are all ones
    for (genvar k = 0; k < TAP_N; k++) begin : g_tap
        if (k == 0) begin : g_unit
            assign stride_en[k] = 1'b1;
        end else if (k <= PRE_MAX) begin : g_carry
            assign stride_en[k] = &ripple_q[k-1:0];
        end else begin : g_none
            assign stride_en[k] = 1'b0;
        end
    end
endmodule

// File: rtl/pwmclk_divider.sv
module pwmclk_divider
    import pwmclk_pkg::*;
#(
    parameter int RATIO_W = 8,
    parameter int EXP_W   = 4,
    parameter int PRE_MAX = 10
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load,
    input  logic [RATIO_W+EXP_W-1:0]   field_new,
    input  logic [RATIO_W+EXP_W-1:0]   field_cur,
    input  logic [(1<<EXP_W)-1:0]      stride_en,
    output logic                       tick
);
    logic [RATIO_W-1:0] cur_ratio, new_ratio, count_q, count_d;
    logic [EXP_W-1:0]   cur_shift, new_shift;
    logic               cfg_changed, new_ok, stride;
    div_state_e         state_q, state_d;

    assign cur_ratio   = field_cur[RATIO_W-1:0];
    assign cur_shift   = field_cur[RATIO_W +: EXP_W];
    assign new_ratio   = field_new[RATIO_W-1:0];
    assign new_shift   = field_new[RATIO_W +: EXP_W];
    assign cfg_changed = (field_new != field_cur);
    assign new_ok      = (new_ratio != '0) && (new_shift <= EXP_W'(PRE_MAX));
    assign stride      = stride_en[cur_shift];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DIV_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (load && cfg_changed) begin
            count_d = '0;
            state_d = new_ok ? DIV_RUN : DIV_IDLE;
        end else begin
            unique case (state_q)
                DIV_IDLE: count_d = '0;
                DIV_RUN: begin
                    if (stride)
                        count_d = (count_q == cur_ratio - RATIO_W'(1)) ? '0 : count_q + 1'b1;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            DIV_IDLE: tick = 1'b0;
            DIV_RUN:  tick = stride && (count_q == cur_ratio - RATIO_W'(1));
        endcase
    end
endmodule

// File: rtl/pwmclk_dual_gen.sv
module pwmclk_dual_gen #(
    parameter int RATIO_W = 8,
    parameter int EXP_W   = 4,
    parameter int PRE_MAX = 10,
    parameter int HALF_W  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2*HALF_W-1:0]  cfg_wdata,
    output logic [2*HALF_W-1:0]  cfg_rdata,
    output logic                 tick_a,
    output logic                 tick_b
);
    localparam int DEC_W = RATIO_W + EXP_W;
    localparam int NCLK  = 2;

    logic [2*HALF_W-1:0]     mode_q;
    logic [(1<<EXP_W)-1:0]   stride_en;
    logic [NCLK-1:0]         tick_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      mode_q <= '0;
        else if (cfg_we) mode_q <= cfg_wdata;
    end

    assign cfg_rdata = mode_q;

    pwmclk_prescaler #(.PRE_MAX(PRE_MAX), .EXP_W(EXP_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .stride_en (stride_en)
    );

    for (genvar h = 0; h < NCLK; h++) begin : g_half
        pwmclk_divider #(.RATIO_W(RATIO_W), .EXP_W(EXP_W), .PRE_MAX(PRE_MAX)) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (cfg_we),
            .field_new (cfg_wdata[h*HALF_W +: DEC_W]),
            .field_cur (mode_q[h*HALF_W +: DEC_W]),
            .stride_en (stride_en),
            .tick      (tick_vec[h])
        );
    end

    assign tick_a = tick_vec[0];
    assign tick_b = tick_vec[1];
endmodule

// File: rtl/pwmclk_dual_gen_chk.sv
module pwmclk_dual_gen_chk #(
    parameter int RATIO_W = 8,
    parameter int EXP_W   = 4,
    parameter int PRE_MAX = 10,
    parameter int HALF_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_we,
    input logic [2*HALF_W-1:0] cfg_wdata,
    input logic [2*HALF_W-1:0] cfg_rdata,
    input logic                tick_a,
    input logic                tick_b
);
    localparam int DEC_W = RATIO_W + EXP_W;
    localparam int B0    = HALF_W;

    AST_A_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[RATIO_W-1:0] == '0 || cfg_rdata[RATIO_W +: EXP_W] > EXP_W'(PRE_MAX)) |-> !tick_a); // R4
    AST_B_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[B0 +: RATIO_W] == '0 || cfg_rdata[B0+RATIO_W +: EXP_W] > EXP_W'(PRE_MAX)) |-> !tick_b); // R4
    AST_A_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[RATIO_W-1:0] > RATIO_W'(1) && cfg_wdata[DEC_W-1:0] != cfg_rdata[DEC_W-1:0]) |=> !tick_a); // R5
    AST_B_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_wdata[B0 +: RATIO_W] > RATIO_W'(1) && cfg_wdata[B0 +: DEC_W] != cfg_rdata[B0 +: DEC_W]) |=> !tick_b); // R5
    AST_A_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[DEC_W-1:0] == DEC_W'(1)) |-> tick_a); // R3
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_rdata)); // R6
endmodule

bind pwmclk_dual_gen pwmclk_dual_gen_chk #(
    .RATIO_W(RATIO_W), .EXP_W(EXP_W), .PRE_MAX(PRE_MAX), .HALF_W(HALF_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .tick_a(tick_a), .tick_b(tick_b)
);

// File: tb/test_pwmclk_dual_gen.sv
module test_pwmclk_dual_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        tick_a, tick_b;
    int          n_total = 0;
    int          n_fail  = 0;

    always #2.5 clk = ~clk;

    pwmclk_dual_gen i_pwmclk_dual_gen (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .tick_a(tick_a), .tick_b(tick_b)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic tk(input bit sel);
        return sel ? tick_b : tick_a;
    endfunction

    task automatic write_cfg(input logic [31:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_pulse(input bit sel, input int limit, input string req);
        int i;
        for (i = 0; i < limit && !tk(sel); i++) @(negedge clk);
        chk(i < limit, req, i, limit);
    endtask

    task automatic measure(input bit sel, input int expect_p, input string req);
        wait_pulse(sel, 2 * expect_p + 8, req);
        for (int r = 0; r < 2; r++) begin
            int n = 0;
            do begin @(negedge clk); n++; end while (!tk(sel) && n < 3 * expect_p + 8);
            chk(n == expect_p, req, n, expect_p);
        end
    endtask

    task automatic silent(input int cycles, input string req);
        int hits = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick_a || tick_b) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    // sync on a pulse of sel, write w while driving sample write_at, expect pulses at p1, p2
    task automatic seq(input int write_at, input logic [31:0] w, input bit sel,
                       input int n, input int p1, input int p2, input string req);
        int bad = 0;
        wait_pulse(sel, 600, req);
        for (int i = 1; i <= n; i++) begin
            cfg_we = (i == write_at); cfg_wdata = w;
            @(negedge clk);
            if (tk(sel) != ((i == p1) || (i == p2))) bad++;
        end
        cfg_we = 1'b0;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset;
        chk(cfg_rdata == 32'h0, "R1", cfg_rdata, 0);
        silent(40, "R1");
    endtask

    task automatic t_readback;
        write_cfg(32'hBEEF_1234);
        chk(cfg_rdata == 32'hBEEF_1234, "R2", cfg_rdata, 32'hBEEF_1234);
        repeat (50) @(negedge clk);
        chk(cfg_rdata == 32'hBEEF_1234, "R6", cfg_rdata, 32'hBEEF_1234);
    endtask

    task automatic t_first_pulse;
        int bad = 0;
        write_cfg(32'h0);
        cfg_we = 1'b1; cfg_wdata = 32'h0000_0007;
        for (int k = 1; k <= 7; k++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            if (tick_a != (k == 7)) bad++;
            if (tick_b) bad++;
        end
        chk(bad == 0, "R5 first pulse at D", bad, 0);
        measure(1'b0, 7, "R3 E0 D7");
    endtask

    task automatic t_periods;
        write_cfg(32'h0001_0305);
        measure(1'b0, 40, "R3 A E3 D5");
        measure(1'b1, 1, "R3 B E0 D1");
        write_cfg(32'h0A02_00FF);
        measure(1'b0, 255, "R3 A E0 D255");
        measure(1'b1, 2048, "R3 B E10 D2");
    endtask

    task automatic t_off;
        write_cfg(32'h0005_0B07);
        measure(1'b1, 5, "R2 B field position");
        begin
            int hits = 0;
            for (int i = 0; i < 3000; i++) begin @(negedge clk); if (tick_a) hits++; end
            chk(hits == 0, "R4 exponent 11", hits, 0);
        end
        write_cfg(32'h0C01_0300);
        silent(3000, "R4 divisor 0 and exponent 12");
    endtask

    task automatic t_write_cases;
        write_cfg(32'h0000_0007);
        seq(3, 32'h0002_0007, 1'b0, 14, 7, 14, "R7 B write keeps A");
        seq(4, 32'h0002_9007, 1'b0, 14, 7, 14, "R8 spare bits no restart");
        chk(cfg_rdata == 32'h0002_9007, "R8 readback", cfg_rdata, 32'h0002_9007);
        seq(3, 32'h0002_9004, 1'b0, 12, 6, 10, "R5 mid-period restart");
        seq(1, 32'h0002_9003, 1'b0, 8, 3, 6, "R5 write on pulse cycle");
        seq(1, 32'h0003_9003, 1'b0, 8, 3, 6, "R7 B write on A pulse cycle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!tick_a && !tick_b && cfg_rdata == 0, "R1 in reset", {tick_a, tick_b}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_first_pulse();
        t_periods();
        t_off();
        t_write_cases();
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule